// File: doc/BRIEF.md
# Serial Port Control Register Block

This block is the processor-facing front end of a buffered asynchronous serial port. A host reaches eight byte-wide registers through a 3-bit address with separate write and read strobes. The block holds the line configuration (word length, parity, stop bits), a 16-bit clock divisor that paces a 16x oversampling tick, the FIFO on/off and flush controls, an interrupt enable mask and a scratch byte. It reports receive and transmit status and raises a single prioritised interrupt request.

The shift logic and the FIFO storage sit outside. They report empty and full flags, receive error pulses and transmitter idle. The block answers with push, pop and flush strobes. When the FIFOs are switched off, the attached FIFOs are expected to behave as one-byte holding registers. The block still issues the same push and pop strobes in that mode.

The bidirectional data path is split into an input byte and an output byte. Read data is captured into a register on the clock edge that accepts the read.

Top module: `sio_regfile`

## Requirements
- R1: Line control (address 3), interrupt enable (address 1, low 4 bits) and scratch (address 7) read back what was written. Addresses 4 and 6 read as 0x00. Writes to addresses 4, 5 and 6 change no register. Reset clears every register and the read data.
- R2: While line-control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. In that state no FIFO push or pop is issued, and the interrupt enable register is untouched.
- R3: When the divisor D is non-zero, `baud_tick16` pulses once every D clock cycles; D = 1 holds it high. Writing either divisor byte restarts the count. A divisor of 0, the reset value, stops the tick.
- R4: The line configuration outputs follow line control: `cfg_wlen` = bits 1:0 (0 means 5 data bits up to 3 meaning 8), `cfg_stop2` = bit 2, `cfg_par_en` = bit 3, `cfg_par_even` = bit 4.
- R5: A write to address 2 sets `fifo_en` from bit 0. Bit 1 gives a one-cycle `rxf_clr` pulse and bit 2 a one-cycle `txf_clr` pulse in the cycle after the write. A change of bit 0 pulses both.
- R6: With line-control bit 7 at 0, a write to address 0 drives `txf_push` high in the write cycle with `txf_wdata` = written byte, unless `txf_full`. A read of address 0 drives `rxf_pop` unless `rxf_empty`, and returns `rxf_rdata`.
- R7: Line status (address 5) is: bit 0 = receive data present, bit 1 overrun, bit 2 parity, bit 3 framing, bit 5 = `txf_empty`, bit 6 = `txf_empty` and `tx_idle`, other bits 0. The three error bits are sticky and cleared by reading address 5.
- R8: `irq` is high exactly when an enabled cause is pending. The enable bits are: bit 0 for receive data, bit 1 for transmitter empty, bit 2 for line errors. The receive cause is `rxf_full` with FIFOs on, and not `rxf_empty` with FIFOs off.
- R9: Identification (read at address 2) reports the highest-priority cause: line error 0x06, then receive data 0x04, then transmitter empty 0x02, with 0x01 when nothing is pending. Bits 7:6 read 11 while FIFOs are on.
- R10: The transmitter-empty cause is set on a rising `txf_empty` or when enable bit 1 goes from 0 to 1 while `txf_empty`. It is cleared by a read of the identification that reports it, or by a data write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_rdata | input | 8 | Receive FIFO head byte |
| rxf_pop | output | 1 | Receive FIFO pop strobe |
| rxf_clr | output | 1 | Receive FIFO flush pulse |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_full | input | 1 | Transmit FIFO full |
| txf_push | output | 1 | Transmit FIFO push strobe |
| txf_wdata | output | 8 | Transmit FIFO push byte |
| txf_clr | output | 1 | Transmit FIFO flush pulse |
| tx_idle | input | 1 | Transmit shifter idle |
| rx_oerr | input | 1 | Receive overrun pulse |
| rx_perr | input | 1 | Receive parity error pulse |
| rx_ferr | input | 1 | Receive framing error pulse |
| fifo_en | output | 1 | FIFOs enabled |
| cfg_wlen | output | 2 | Data length code (0 = 5 bits up to 3 = 8 bits) |
| cfg_stop2 | output | 1 | Long stop setting |
| cfg_par_en | output | 1 | Parity enabled |
| cfg_par_even | output | 1 | Even parity selected |
| baud_tick16 | output | 1 | 16x baud clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:
- a zero divisor keeps the tick quiet;
- an enabled line error always wins the identification;
- the flush pulses do not repeat without a new control write, and no FIFO strobe appears while divisor access is on;
- reading line status empties the error bits, and a cleared enable mask keeps the request low.

Other behaviours depend on a chosen sequence of events, so only the bench scenarios can show them:
- the exact tick period for a given divisor;
- the full priority walk from line error down to nothing pending;
- arming the transmitter-empty cause through the enable register, and clearing it by an identification read or a data write;
- the different receive cause with FIFOs on and with FIFOs off.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int IER_W  = 4;
    localparam int ERR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA = 3'd0, A_IER = 3'd1, A_IDFC = 3'd2, A_LCTL = 3'd3,
        A_RSV4 = 3'd4, A_LSTS = 3'd5, A_RSV6 = 3'd6, A_SCR  = 3'd7
    } reg_addr_e;

    typedef enum logic [2:0] {
        ID_NONE = 3'b000,
        ID_THRE = 3'b001,
        ID_RXDA = 3'b010,
        ID_LINE = 3'b011
    } irq_id_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop2;
        logic       par_en;
        logic       par_even;
    } line_cfg_t;

    function automatic logic [BYTE_W-1:0] iir_byte(irq_id_e id, logic fen);
        return {fen, fen, 2'b00, id, (id == ID_NONE)};
    endfunction

    function automatic line_cfg_t decode_lcr(logic [BYTE_W-1:0] lcr);
        line_cfg_t c;
        c.wlen     = lcr[1:0];
        c.stop2    = lcr[2];
        c.par_en   = lcr[3];
        c.par_even = lcr[4];
        return c;
    endfunction
endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || div == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == div - W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl import sio_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic [2:0] ier,
    input  logic    line_err,
    input  logic    rx_cause,
    input  logic    txf_empty,
    input  logic    thre_arm,
    input  logic    thr_wr,
    input  logic    iir_rd,
    output irq_id_e irq_id,
    output logic    irq
);
    logic thre_pend;
    logic tx_prev;

    always_comb begin
        if (ier[2] && line_err)       irq_id = ID_LINE;
        else if (ier[0] && rx_cause)  irq_id = ID_RXDA;
        else if (ier[1] && thre_pend) irq_id = ID_THRE;
        else                          irq_id = ID_NONE;
    end

    assign irq = (irq_id != ID_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            thre_pend <= 1'b0;
            tx_prev   <= 1'b1;
        end else begin
            tx_prev <= txf_empty;
            if ((txf_empty && !tx_prev) || thre_arm)
                thre_pend <= 1'b1;
            else if (thr_wr || (iir_rd && irq_id == ID_THRE))
                thre_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile import sio_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic [BYTE_W-1:0] rxf_rdata,
    output logic              rxf_pop,
    output logic              rxf_clr,
    input  logic              txf_empty,
    input  logic              txf_full,
    output logic              txf_push,
    output logic [BYTE_W-1:0] txf_wdata,
    output logic              txf_clr,
    input  logic              tx_idle,
    input  logic              rx_oerr,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              fifo_en,
    output logic [1:0]        cfg_wlen,
    output logic              cfg_stop2,
    output logic              cfg_par_en,
    output logic              cfg_par_even,
    output logic              baud_tick16,
    output logic              irq
);
    logic [BYTE_W-1:0] lcr_q, scr_q, dll_q, dlm_q, lsr, rd_mux;
    logic [IER_W-1:0]  ier_q;
    logic [ERR_W-1:0]  err_q;
    logic              fen_q, dlab;
    logic              data_wr, ier_wr, div_wr, fcr_wr, lsr_rd, iir_rd, thre_arm;
    logic [DIV_W-1:0]  divisor;
    line_cfg_t         cfg;
    irq_id_e           irq_id;

    assign dlab     = lcr_q[7];
    assign data_wr  = cpu_wr && cpu_addr == A_DATA && !dlab;
    assign ier_wr   = cpu_wr && cpu_addr == A_IER && !dlab;
    assign div_wr   = cpu_wr && dlab && (cpu_addr == A_DATA || cpu_addr == A_IER);
    assign fcr_wr   = cpu_wr && cpu_addr == A_IDFC;
    assign lsr_rd   = cpu_rd && cpu_addr == A_LSTS;
    assign iir_rd   = cpu_rd && cpu_addr == A_IDFC;
    assign thre_arm = ier_wr && cpu_wdata[1] && !ier_q[1] && txf_empty;

    assign txf_push  = data_wr && !txf_full;
    assign txf_wdata = cpu_wdata;
    assign rxf_pop   = cpu_rd && cpu_addr == A_DATA && !dlab && !rxf_empty;

    assign divisor = {dlm_q, dll_q};
    assign cfg     = decode_lcr(lcr_q);
    assign cfg_wlen     = cfg.wlen;
    assign cfg_stop2    = cfg.stop2;
    assign cfg_par_en   = cfg.par_en;
    assign cfg_par_even = cfg.par_even;
    assign fifo_en      = fen_q;

    assign lsr = {1'b0, txf_empty && tx_idle, txf_empty, 1'b0, err_q, !rxf_empty};

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q   <= '0;
            scr_q   <= '0;
            dll_q   <= '0;
            dlm_q   <= '0;
            ier_q   <= '0;
            fen_q   <= 1'b0;
            rxf_clr <= 1'b0;
            txf_clr <= 1'b0;
            err_q   <= '0;
        end else begin
            rxf_clr <= 1'b0;
            txf_clr <= 1'b0;
            if (cpu_wr) begin
                case (reg_addr_e'(cpu_addr))
                    A_DATA: if (dlab) dll_q <= cpu_wdata;
                    A_IER:  if (dlab) dlm_q <= cpu_wdata;
                            else      ier_q <= cpu_wdata[IER_W-1:0];
                    A_IDFC: begin
                        fen_q   <= cpu_wdata[0];
                        rxf_clr <= cpu_wdata[1] || (cpu_wdata[0] != fen_q);
                        txf_clr <= cpu_wdata[2] || (cpu_wdata[0] != fen_q);
                    end
                    A_LCTL: lcr_q <= cpu_wdata;
                    A_SCR:  scr_q <= cpu_wdata;
                    default: ;
                endcase
            end
            err_q <= (lsr_rd ? '0 : err_q) | {rx_ferr, rx_perr, rx_oerr};
        end
    end

    always_comb begin
        case (reg_addr_e'(cpu_addr))
            A_DATA:  rd_mux = dlab ? dll_q : rxf_rdata;
            A_IER:   rd_mux = dlab ? dlm_q : {{(BYTE_W-IER_W){1'b0}}, ier_q};
            A_IDFC:  rd_mux = iir_byte(irq_id, fen_q);
            A_LCTL:  rd_mux = lcr_q;
            A_LSTS:  rd_mux = lsr;
            A_SCR:   rd_mux = scr_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         cpu_rdata <= '0;
        else if (cpu_rd) cpu_rdata <= rd_mux;
    end

    sio_baud_gen #(.W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div(divisor), .restart(div_wr), .tick(baud_tick16)
    );

    sio_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .ier(ier_q[2:0]), .line_err(|err_q),
        .rx_cause(fen_q ? rxf_full : !rxf_empty), .txf_empty(txf_empty),
        .thre_arm(thre_arm), .thr_wr(data_wr), .iir_rd(iir_rd),
        .irq_id(irq_id), .irq(irq)
    );
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] cpu_addr,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [15:0] divisor,
    input logic       tick,
    input logic [3:0] ier,
    input logic [2:0] err,
    input logic [2:0] irq_id,
    input logic       rxf_clr,
    input logic       txf_push,
    input logic       rxf_pop,
    input logic       dlab,
    input logic [2:0] rx_errs,
    input logic       irq
);
    AST_DIV_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (divisor == 16'd0 && $past(divisor) == 16'd0) |-> !tick); // R3

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ier[2] && err != 3'b000) |-> irq_id == 3'b011); // R9

    AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        rxf_clr |=> (!rxf_clr || $past(cpu_wr && cpu_addr == 3'd2))); // R5

    AST_DLAB_NO_FIFO: assert property (@(posedge clk) disable iff (rst)
        dlab |-> (!txf_push && !rxf_pop)); // R2

    AST_LSR_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == 3'd5 && rx_errs == 3'b000) |=> err == 3'b000); // R7

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ier == 4'd0) |-> !irq); // R8
endmodule

bind sio_regfile sio_regfile_chk u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .divisor(divisor), .tick(baud_tick16), .ier(ier_q), .err(err_q),
    .irq_id(irq_id), .rxf_clr(rxf_clr), .txf_push(txf_push), .rxf_pop(rxf_pop),
    .dlab(dlab), .rx_errs({rx_ferr, rx_perr, rx_oerr}), .irq(irq)
);

// File: tb/sio_regfile_tb.sv
module sio_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cpu_addr = '0;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic rxf_empty = 1'b1, rxf_full = 1'b0, rxf_pop, rxf_clr;
    logic [7:0] rxf_rdata = '0, txf_wdata;
    logic txf_empty = 1'b1, txf_full = 1'b0, txf_push, txf_clr;
    logic tx_idle = 1'b1, rx_oerr = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
    logic fifo_en, cfg_stop2, cfg_par_en, cfg_par_even, baud_tick16, irq;
    logic [1:0] cfg_wlen;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regfile u_dut (.*);

    // {is_write, addr, data, expected read}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 8'h1B, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h1B},
        {1'b1, 3'd7, 8'hA5, 8'h00}, {1'b0, 3'd7, 8'h00, 8'hA5},
        {1'b1, 3'd1, 8'h05, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h05},
        {1'b1, 3'd4, 8'hFF, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h00},
        {1'b0, 3'd6, 8'h00, 8'h00}, {1'b1, 3'd3, 8'h9B, 8'h00},
        {1'b1, 3'd0, 8'h34, 8'h00}, {1'b1, 3'd1, 8'h12, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h34}, {1'b0, 3'd1, 8'h00, 8'h12},
        {1'b1, 3'd3, 8'h1B, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h05},
        {1'b0, 3'd3, 8'h00, 8'h1B}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(posedge clk); #1;
        d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] lo, input logic [7:0] hi);
        wr(3'd3, 8'h9B); wr(3'd0, lo); wr(3'd1, hi); wr(3'd3, 8'h1B);
    endtask

    task automatic period(output int n);
        int k = 0;
        while (!baud_tick16 && k < 300) begin @(negedge clk); k++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!baud_tick16 && n < 300);
    endtask

    task automatic pulse_err(input int which);
        @(negedge clk);
        if (which == 0) rx_oerr = 1'b1;
        if (which == 1) rx_perr = 1'b1;
        if (which == 2) rx_ferr = 1'b1;
        @(negedge clk);
        rx_oerr = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11-style reset checks under R1, R3, R9
        chk("R1 reset rdata", cpu_rdata, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);
        chk("R5 reset fifo_en", {7'd0, fifo_en}, 8'h00);
        n = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); n += int'(baud_tick16); end
        chk("R3 reset no tick", 8'(n), 8'h00);
        rd(3'd2, d); chk("R9 reset iir", d, 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][18:16], d);
                chk($sformatf("R1 R2 vector %0d", i), d, VEC[i][7:0]);
            end
        end

        // R4 line configuration outputs
        chk("R4 cfg 1B", {3'd0, cfg_wlen, cfg_stop2, cfg_par_en, cfg_par_even}, 8'b000_11_0_1_1);
        wr(3'd3, 8'h04);
        chk("R4 cfg 04", {3'd0, cfg_wlen, cfg_stop2, cfg_par_en, cfg_par_even}, 8'b000_00_1_0_0);

        // R3 tick period
        set_div(8'h03, 8'h00); period(n); chk("R3 period 3", 8'(n), 8'd3);
        set_div(8'h07, 8'h00); period(n); chk("R3 period 7", 8'(n), 8'd7);
        set_div(8'h01, 8'h00); period(n); chk("R3 period 1", 8'(n), 8'd1);
        set_div(8'h00, 8'h00);
        n = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); n += int'(baud_tick16); end
        chk("R3 zero divisor", 8'(n), 8'h00);

        // R5 FIFO control
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = 3'd2; cpu_wdata = 8'h01;
        @(posedge clk); #1;
        chk("R5 enable pulses", {6'd0, rxf_clr, txf_clr}, 8'h03);
        chk("R5 fifo_en", {7'd0, fifo_en}, 8'h01);
        @(negedge clk); cpu_wr = 1'b0;
        @(posedge clk); #1;
        chk("R5 pulse self clears", {6'd0, rxf_clr, txf_clr}, 8'h00);
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = 3'd2; cpu_wdata = 8'h03;
        @(posedge clk); #1;
        chk("R5 rx flush only", {6'd0, rxf_clr, txf_clr}, 8'h02);
        @(negedge clk); cpu_wr = 1'b0;
        rd(3'd2, d); chk("R9 fifo bits", d, 8'hC1);

        // R6 data path
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = 3'd0; cpu_wdata = 8'h3C; #1;
        chk("R6 push", {txf_push, 7'd0}, 8'h80);
        chk("R6 push data", txf_wdata, 8'h3C);
        txf_full = 1'b1; #1;
        chk("R6 push blocked when full", {7'd0, txf_push}, 8'h00);
        @(negedge clk); cpu_wr = 1'b0; txf_full = 1'b0;
        rxf_empty = 1'b0; rxf_rdata = 8'h5A;
        @(negedge clk); cpu_rd = 1'b1; cpu_addr = 3'd0; #1;
        chk("R6 pop", {7'd0, rxf_pop}, 8'h01);
        @(posedge clk); #1; chk("R6 read data", cpu_rdata, 8'h5A);
        @(negedge clk); rxf_empty = 1'b1; #1;
        chk("R6 pop blocked when empty", {7'd0, rxf_pop}, 8'h00);
        cpu_rd = 1'b0;
        // R2 no push under divisor access
        wr(3'd3, 8'h9B);
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = 3'd0; cpu_wdata = 8'h00; #1;
        chk("R2 no push with access bit", {7'd0, txf_push}, 8'h00);
        @(negedge clk); cpu_wr = 1'b0;
        wr(3'd3, 8'h1B);

        // R7 line status
        rxf_empty = 1'b0;
        pulse_err(1);
        rd(3'd5, d); chk("R7 parity sticky", d, 8'h65);
        rd(3'd5, d); chk("R7 cleared by read", d, 8'h61);
        tx_idle = 1'b0;
        rd(3'd5, d); chk("R7 shifter busy", d, 8'h21);
        tx_idle = 1'b1; rxf_empty = 1'b1;

        // R9 / R10 priority walk with FIFOs on; enabling bit 1 arms the empty cause
        wr(3'd1, 8'h07);
        pulse_err(2);
        chk("R8 irq on line error", {7'd0, irq}, 8'h01);
        rd(3'd2, d); chk("R9 line first", d, 8'hC6);
        rxf_full = 1'b1; rxf_empty = 1'b0;
        rd(3'd5, d); chk("R7 framing bit", d, 8'h69);
        rd(3'd2, d); chk("R9 receive second", d, 8'hC4);
        rxf_full = 1'b0;
        rd(3'd2, d); chk("R8 R9 no receive cause below full", d, 8'hC2);
        rd(3'd2, d); chk("R10 cleared by iir read", d, 8'hC1);
        @(negedge clk); chk("R10 irq low", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h00);
        rd(3'd2, d); chk("R8 receive cause without FIFOs", d, 8'h04);
        rxf_empty = 1'b1;

        // R10 rising empty, cleared by data write
        @(negedge clk); txf_empty = 1'b0;
        @(negedge clk); txf_empty = 1'b1;
        @(negedge clk);
        chk("R10 rise sets irq", {7'd0, irq}, 8'h01);
        rd(3'd2, d); chk("R10 id empty", d, 8'h02);
        @(negedge clk); txf_empty = 1'b0;
        @(negedge clk); txf_empty = 1'b1;
        wr(3'd0, 8'h11);
        @(negedge clk); chk("R10 data write clears", {7'd0, irq}, 8'h00);

        // R8 masked causes stay quiet
        wr(3'd1, 8'h00);
        pulse_err(0);
        @(negedge clk); chk("R8 masked error", {7'd0, irq}, 8'h00);
        rd(3'd5, d); chk("R7 overrun bit", d, 8'h62);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule